// File: doc/BRIEF.md
# Zoned block-mapped translation controller

This controller turns logical page reads and writes into a stream of raw flash commands (read, program, erase, copy) with physical page addresses. The logical space is cut into independent zones; a logical block in a zone may only live in a physical block of the same zone. Translation works at erase-block granularity. A per-zone table holds, for each logical block, its physical block and a bitmap of pages that hold data. The physical page is then the mapped block with the logical page offset appended.

Each zone owns a FIFO of erased physical blocks. Every overwrite takes a fresh block from the head of that FIFO. The other valid pages of the old block are copied into it, in ascending page order, with the new data programmed at its own offset. The old block is then erased and appended at the tail. Stale data never persists, and repeated writes to one logical address rotate through the zone's free blocks plus the active one. A block whose program, copy or erase reports an error is dropped and never reused. The host side accepts one request at a time and reports completion with a one-cycle done pulse.

Top module: `zbm_xlate_ctrl`

## Requirements
- R1: A logical page number is {zone, logical block, page} and a physical page number is {zone, physical block, page}, each field an unsigned integer with the page in the low bits. Every command addresses the same zone as the request and the page offset of its target.
- R2: A write to a logical block that has never been mapped pops the head of its zone's free FIFO and issues a single program command (op 1) to that block at the page offset, with no copy and no erase.
- R3: A write to a mapped block pops a new block from the head of the free FIFO. It then walks pages in ascending order: a copy (op 3, source = old block at the same offset) for every other page holding data, and a program (op 1) at the target page. Last comes one erase (op 2) addressed to page 0 of the old block.
- R4: After reset, each zone's free FIFO holds physical blocks 0 up to the zone size minus one, in that order. A successfully erased old block is appended at the tail.
- R5: An erase that returns an error leaves the old block out of the free FIFO permanently. The write's new data is kept, and the request ends with the error flag set.
- R6: A program or copy that returns an error ends the request at once with the error flag set. The new block is dropped, no erase is issued and the mapping keeps its previous contents.
- R7: A read of a page holding data issues one read command (op 0) and returns the flash data. A read of a page without data returns all ones and issues no command.
- R8: A logical block index at or above the number of logical blocks per zone (zone size minus spare count) is rejected with the error flag and no command.
- R9: A write whose zone has an empty free FIFO is rejected with the error flag, issues no command and leaves the mapping unchanged.
- R10: busy goes high the cycle after a request is accepted and stays high through the one-cycle done pulse, then drops. Requests presented while busy are ignored.
- R11: A command stays valid with stable fields until the flash signals completion. Only one command is outstanding, op codes are read 0, program 1, erase 2, copy 3, and the source field is zero except for copies and the write-data field is zero except for programs.
- R12: During and after reset, busy, done and command-valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; accepted when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_lpn_i | input | 7 | Logical page number {zone, block, page} |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done |
| rd_data_o | output | 16 | Read data, valid with done |
| cmd_valid_o | output | 1 | Flash command valid |
| cmd_op_o | output | 2 | Command op code |
| cmd_addr_o | output | 7 | Target physical page |
| cmd_src_o | output | 7 | Copy source physical page |
| cmd_wdata_o | output | 16 | Program data |
| fl_done_i | input | 1 | Flash completion for the current command |
| fl_err_i | input | 1 | Flash error status, valid with fl_done_i |
| fl_rdata_i | input | 16 | Flash read data, valid with fl_done_i |

## Verification
On every cycle, the assertions hold commands stable until completion and keep done to a single cycle followed by idle. They also check that busy follows an accepted request, that no free FIFO is popped empty or pushed past its depth, and that an erase never targets the block just allocated. Only the bench scenarios can show the actual block rotation order and the exact ascending copy and program sequence with its source addresses. The same holds for dropping blocks after injected program and erase errors, exhausting a zone's free list, and read-back of merged data. Those scenarios compare every command against a reference model of the map and the free FIFOs.

// File: rtl/zbm_pkg.sv
package zbm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_COPY  = 2'd3
  } flash_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_ALLOC,
    S_MERGE,
    S_ERASE,
    S_RESP
  } seq_state_e;
endpackage

// File: rtl/zbm_free_fifo.sv
module zbm_free_fifo #(
  parameter int DEPTH = 8,
  parameter int BW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [BW-1:0] push_blk_i,
  output logic [BW-1:0] head_o,
  output logic          empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [BW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= BW'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      if (pop_i) rd_q <= nxt(rd_q);
      if (push_i) begin
        mem_q[wr_q] <= push_blk_i;
        wr_q        <= nxt(wr_q);
      end
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);

  a_r9_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
  a_r4_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CW'(DEPTH));
endmodule

// File: rtl/zbm_map_table.sv
module zbm_map_table #(
  parameter int N_ENT = 24,
  parameter int BW    = 3,
  parameter int PAGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [$clog2(N_ENT)-1:0] idx_i,
  output logic             vld_o,
  output logic [BW-1:0]    pblk_o,
  output logic [PAGES-1:0] pv_o,
  input  logic             we_i,
  input  logic [BW-1:0]    wpblk_i,
  input  logic [PAGES-1:0] wpv_i
);
  localparam int IW = $clog2(N_ENT);

  logic             vld_q [N_ENT];
  logic [BW-1:0]    pb_q  [N_ENT];
  logic [PAGES-1:0] pv_q  [N_ENT];
  logic             idx_ok;

  assign idx_ok = ({1'b0, idx_i} < (IW+1)'(N_ENT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) begin
        vld_q[i] <= 1'b0;
        pb_q[i]  <= '0;
        pv_q[i]  <= '0;
      end
    end else if (we_i && idx_ok) begin
      vld_q[idx_i] <= 1'b1;
      pb_q[idx_i]  <= wpblk_i;
      pv_q[idx_i]  <= wpv_i;
    end
  end

  assign vld_o  = idx_ok && vld_q[idx_i];
  assign pblk_o = idx_ok ? pb_q[idx_i] : '0;
  assign pv_o   = idx_ok ? pv_q[idx_i] : '0;

  // a mapped block always carries at least one page of data
  a_r2_wr_has_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (idx_ok && wpv_i != '0));
endmodule

// File: rtl/zbm_seq.sv
module zbm_seq
  import zbm_pkg::*;
#(
  parameter int N_ZONES   = 4,
  parameter int ZONE_BLKS = 8,
  parameter int LBLKS     = 6,
  parameter int PAGES     = 4,
  parameter int DW        = 16,
  localparam int ZW    = $clog2(N_ZONES),
  localparam int BW    = $clog2(ZONE_BLKS),
  localparam int PW    = $clog2(PAGES),
  localparam int LBW   = $clog2(LBLKS),
  localparam int IW    = $clog2(N_ZONES * LBLKS),
  localparam int LPN_W = ZW + LBW + PW,
  localparam int PPN_W = ZW + BW + PW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [LPN_W-1:0] req_lpn_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [PPN_W-1:0] cmd_addr_o,
  output logic [PPN_W-1:0] cmd_src_o,
  output logic [DW-1:0]    cmd_wdata_o,
  input  logic             fl_done_i,
  input  logic             fl_err_i,
  input  logic [DW-1:0]    fl_rdata_i,
  output logic [IW-1:0]    map_idx_o,
  input  logic             map_vld_i,
  input  logic [BW-1:0]    map_pblk_i,
  input  logic [PAGES-1:0] map_pv_i,
  output logic             map_we_o,
  output logic [BW-1:0]    map_wpblk_o,
  output logic [PAGES-1:0] map_wpv_o,
  output logic [ZW-1:0]    zone_o,
  input  logic             fifo_empty_i,
  input  logic [BW-1:0]    fifo_head_i,
  output logic             pop_o,
  output logic             push_o,
  output logic [BW-1:0]    push_blk_o
);
  seq_state_e       state_q;
  logic [ZW-1:0]    zone_q;
  logic [LBW-1:0]   lblk_q;
  logic [PW-1:0]    page_q, pidx_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             old_vld_q, err_q;
  logic [BW-1:0]    old_pb_q, new_pb_q;
  logic [PAGES-1:0] pvs_q;

  logic [PW-1:0]  in_page;
  logic [LBW-1:0] in_lblk;
  logic [ZW-1:0]  in_zone;
  logic           in_range, rd_hit, is_tgt, is_cp, need_cmd, step_ok, last_pg;
  flash_op_e      op;

  assign in_page  = req_lpn_i[PW-1:0];
  assign in_lblk  = req_lpn_i[PW +: LBW];
  assign in_zone  = req_lpn_i[PW+LBW +: ZW];
  assign in_range = ({1'b0, in_lblk} < (LBW+1)'(LBLKS));

  assign map_idx_o = IW'(zone_q) * IW'(LBLKS) + IW'(lblk_q);
  assign zone_o    = zone_q;

  assign rd_hit   = map_vld_i && map_pv_i[page_q];
  assign is_tgt   = (pidx_q == page_q);
  assign is_cp    = old_vld_q && pvs_q[pidx_q] && !is_tgt;
  assign need_cmd = is_tgt || is_cp;
  assign step_ok  = !need_cmd || (fl_done_i && !fl_err_i);
  assign last_pg  = (pidx_q == PW'(PAGES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      zone_q    <= '0;
      lblk_q    <= '0;
      page_q    <= '0;
      pidx_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      old_vld_q <= 1'b0;
      err_q     <= 1'b0;
      old_pb_q  <= '0;
      new_pb_q  <= '0;
      pvs_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          zone_q  <= in_zone;
          lblk_q  <= in_lblk;
          page_q  <= in_page;
          wdata_q <= req_wdata_i;
          rdata_q <= '1;
          err_q   <= !in_range;
          if (!in_range)        state_q <= S_RESP;
          else if (req_write_i) state_q <= S_ALLOC;
          else                  state_q <= S_READ;
        end
        S_READ: begin
          if (!rd_hit) state_q <= S_RESP;
          else if (fl_done_i) begin
            rdata_q <= fl_rdata_i;
            err_q   <= fl_err_i;
            state_q <= S_RESP;
          end
        end
        S_ALLOC: begin
          if (fifo_empty_i) begin
            err_q   <= 1'b1;
            state_q <= S_RESP;
          end else begin
            new_pb_q  <= fifo_head_i;
            old_vld_q <= map_vld_i;
            old_pb_q  <= map_pblk_i;
            pvs_q     <= map_vld_i ? map_pv_i : '0;
            pidx_q    <= '0;
            state_q   <= S_MERGE;
          end
        end
        S_MERGE: begin
          if (need_cmd && fl_done_i && fl_err_i) begin
            err_q   <= 1'b1;
            state_q <= S_RESP;
          end else if (step_ok) begin
            if (last_pg) state_q <= old_vld_q ? S_ERASE : S_RESP;
            else         pidx_q  <= pidx_q + 1'b1;
          end
        end
        S_ERASE: if (fl_done_i) begin
          err_q   <= err_q | fl_err_i;
          state_q <= S_RESP;
        end
        S_RESP:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pop_o       = (state_q == S_ALLOC) && !fifo_empty_i;
  assign push_o      = (state_q == S_ERASE) && fl_done_i && !fl_err_i;
  assign push_blk_o  = old_pb_q;
  assign map_we_o    = (state_q == S_MERGE) && step_ok && last_pg;
  assign map_wpblk_o = new_pb_q;
  assign map_wpv_o   = pvs_q | (PAGES'(1) << page_q);

  always_comb begin
    cmd_valid_o = 1'b0;
    op          = OP_READ;
    cmd_addr_o  = '0;
    cmd_src_o   = '0;
    cmd_wdata_o = '0;
    case (state_q)
      S_READ: begin
        cmd_valid_o = rd_hit;
        cmd_addr_o  = {zone_q, map_pblk_i, page_q};
      end
      S_MERGE: begin
        cmd_valid_o = need_cmd;
        cmd_addr_o  = {zone_q, new_pb_q, pidx_q};
        if (is_tgt) begin
          op          = OP_PROG;
          cmd_wdata_o = wdata_q;
        end else begin
          op        = OP_COPY;
          cmd_src_o = {zone_q, old_pb_q, pidx_q};
        end
      end
      S_ERASE: begin
        cmd_valid_o = 1'b1;
        op          = OP_ERASE;
        cmd_addr_o  = {zone_q, old_pb_q, PW'(0)};
      end
      default: ;
    endcase
  end
  assign cmd_op_o = op;

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_RESP);
  assign err_o     = done_o && err_q;
  assign rd_data_o = rdata_q;

  a_r11_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !fl_done_i) |=>
      (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_op_o) && $stable(cmd_src_o)));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  a_r10_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> busy_o);
  a_r3_erase_not_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_ERASE) |-> (cmd_addr_o[PW +: BW] != new_pb_q));
endmodule

// File: rtl/zbm_xlate_ctrl.sv
module zbm_xlate_ctrl #(
  parameter int N_ZONES    = 4,
  parameter int ZONE_BLKS  = 8,
  parameter int SPARE_BLKS = 2,
  parameter int PAGES      = 4,
  parameter int DW         = 16,
  localparam int LBLKS = ZONE_BLKS - SPARE_BLKS,
  localparam int ZW    = $clog2(N_ZONES),
  localparam int BW    = $clog2(ZONE_BLKS),
  localparam int PW    = $clog2(PAGES),
  localparam int LBW   = $clog2(LBLKS),
  localparam int N_ENT = N_ZONES * LBLKS,
  localparam int IW    = $clog2(N_ENT),
  localparam int LPN_W = ZW + LBW + PW,
  localparam int PPN_W = ZW + BW + PW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [LPN_W-1:0] req_lpn_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [PPN_W-1:0] cmd_addr_o,
  output logic [PPN_W-1:0] cmd_src_o,
  output logic [DW-1:0]    cmd_wdata_o,
  input  logic             fl_done_i,
  input  logic             fl_err_i,
  input  logic [DW-1:0]    fl_rdata_i
);
  logic [IW-1:0]    map_idx;
  logic             map_vld, map_we;
  logic [BW-1:0]    map_pblk, map_wpblk;
  logic [PAGES-1:0] map_pv, map_wpv;
  logic [ZW-1:0]    zone;
  logic             pop, push;
  logic [BW-1:0]    push_blk;

  logic [N_ZONES-1:0] pop_z, push_z, empty_z;
  logic [BW-1:0]      head_z [N_ZONES];

  zbm_seq #(
    .N_ZONES(N_ZONES), .ZONE_BLKS(ZONE_BLKS), .LBLKS(LBLKS),
    .PAGES(PAGES), .DW(DW)
  ) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_lpn_i, .req_wdata_i,
    .busy_o, .done_o, .err_o, .rd_data_o,
    .cmd_valid_o, .cmd_op_o, .cmd_addr_o, .cmd_src_o, .cmd_wdata_o,
    .fl_done_i, .fl_err_i, .fl_rdata_i,
    .map_idx_o(map_idx), .map_vld_i(map_vld), .map_pblk_i(map_pblk), .map_pv_i(map_pv),
    .map_we_o(map_we), .map_wpblk_o(map_wpblk), .map_wpv_o(map_wpv),
    .zone_o(zone), .fifo_empty_i(empty_z[zone]), .fifo_head_i(head_z[zone]),
    .pop_o(pop), .push_o(push), .push_blk_o(push_blk)
  );

  zbm_map_table #(.N_ENT(N_ENT), .BW(BW), .PAGES(PAGES)) u_map (
    .clk_i, .rst_ni,
    .idx_i(map_idx), .vld_o(map_vld), .pblk_o(map_pblk), .pv_o(map_pv),
    .we_i(map_we), .wpblk_i(map_wpblk), .wpv_i(map_wpv)
  );

  for (genvar z = 0; z < N_ZONES; z++) begin : g_zone
    assign pop_z[z]  = pop  && (zone == ZW'(z));
    assign push_z[z] = push && (zone == ZW'(z));
    zbm_free_fifo #(.DEPTH(ZONE_BLKS), .BW(BW)) u_fifo (
      .clk_i, .rst_ni,
      .pop_i(pop_z[z]), .push_i(push_z[z]), .push_blk_i(push_blk),
      .head_o(head_z[z]), .empty_o(empty_z[z])
    );
  end

  a_r12_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> (!cmd_valid_o && !done_o));
  a_r11_single_zone_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pop, push}));
endmodule

// File: tb/sim_zbm_xlate_ctrl.sv
`timescale 1ns/1ps
module sim_zbm_xlate_ctrl;
  localparam int NZ = 4, ZB = 8, LB = 6, PG = 4;
  localparam int OP_RD = 0, OP_PR = 1, OP_ER = 2, OP_CP = 3;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [6:0]  req_lpn_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        busy_o, done_o, err_o, cmd_valid_o;
  logic [15:0] rd_data_o, cmd_wdata_o;
  logic [1:0]  cmd_op_o;
  logic [6:0]  cmd_addr_o, cmd_src_o;
  logic        fl_done_i = 1'b0, fl_err_i = 1'b0;
  logic [15:0] fl_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  zbm_xlate_ctrl u0 (.*);

  int checks = 0, fails = 0;
  int inj_op = -1;
  int wait_cnt = 0;
  logic [15:0] fmem [128];
  logic [31:0] got_q[$], exp_q[$];

  // reference model
  bit   r_vld [NZ*LB];
  int   r_pb  [NZ*LB];
  int   r_pv  [NZ*LB];
  int   fq [NZ][ZB];
  int   fh [NZ], fc [NZ];
  logic [15:0] r_data [128];

  function automatic logic [6:0] ppn(int z, int b, int p);
    return 7'((z << 5) | (b << 2) | p);
  endfunction
  function automatic logic [31:0] mk(int op, logic [6:0] a, logic [6:0] s, logic [15:0] w);
    return {2'(op), a, s, w};
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // flash model
  always @(posedge clk_i) begin
    fl_done_i <= 1'b0;
    fl_err_i  <= 1'b0;
    if (rst_ni && cmd_valid_o && !fl_done_i) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        got_q.push_back({cmd_op_o, cmd_addr_o, cmd_src_o, cmd_wdata_o});
        case (int'(cmd_op_o))
          OP_RD: fl_rdata_i <= fmem[cmd_addr_o];
          OP_PR: fmem[cmd_addr_o] = cmd_wdata_o;
          OP_CP: fmem[cmd_addr_o] = fmem[cmd_src_o];
          default: for (int k = 0; k < PG; k++) fmem[{cmd_addr_o[6:2], 2'(k)}] = 16'hFFFF;
        endcase
        if (int'(cmd_op_o) == inj_op) begin
          fl_err_i <= 1'b1;
          inj_op = -1;
        end
        fl_done_i <= 1'b1;
        wait_cnt = $urandom % 3;
      end
    end
  end

  task automatic do_req(bit wr, int z, int l, int p, logic [15:0] d, int inj, bit spur, string tag);
    int idx, lpn, nb, old, n;
    bit ok, exp_err;
    logic [15:0] exp_rd;
    lpn = (z << 5) | (l << 2) | p;
    idx = z * LB + l;
    exp_err = 0;
    exp_rd = 16'hFFFF;
    exp_q.delete();
    got_q.delete();
    if (l >= LB) exp_err = 1;
    else if (!wr) begin
      if (r_vld[idx] && r_pv[idx][p]) begin
        exp_q.push_back(mk(OP_RD, ppn(z, r_pb[idx], p), 0, 0));
        exp_rd = r_data[lpn];
      end
    end else if (fc[z] == 0) exp_err = 1;
    else begin
      nb = fq[z][fh[z]];
      fh[z] = (fh[z] + 1) % ZB;
      fc[z]--;
      ok = 1;
      for (int q = 0; q < PG; q++) begin
        if (q == p) begin
          exp_q.push_back(mk(OP_PR, ppn(z, nb, q), 0, d));
          if (inj == OP_PR) begin ok = 0; break; end
        end else if (r_vld[idx] && r_pv[idx][q])
          exp_q.push_back(mk(OP_CP, ppn(z, nb, q), ppn(z, r_pb[idx], q), 0));
      end
      if (!ok) exp_err = 1;
      else begin
        old = r_pb[idx];
        if (r_vld[idx]) begin
          exp_q.push_back(mk(OP_ER, ppn(z, old, 0), 0, 0));
          if (inj == OP_ER) exp_err = 1;
          else begin
            fq[z][(fh[z] + fc[z]) % ZB] = old;
            fc[z]++;
          end
          r_pv[idx] = r_pv[idx] | (1 << p);
        end else r_pv[idx] = 1 << p;
        r_vld[idx] = 1;
        r_pb[idx]  = nb;
        r_data[lpn] = d;
      end
    end

    @(negedge clk_i);
    inj_op = inj;
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_lpn_i   = 7'(lpn);
    req_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(busy_o === 1'b1, "R10", "busy after accept", busy_o, 1);
    if (spur) begin
      req_write_i = 1'b1;
      req_lpn_i   = 7'((0 << 5) | (5 << 2) | 3);
      req_wdata_i = 16'h5555;
    end else req_valid_i = 1'b0;
    n = 0;
    while (done_o !== 1'b1 && n < 300) begin
      @(negedge clk_i);
      n++;
    end
    req_valid_i = 1'b0;
    inj_op = -1;
    chk(done_o === 1'b1, tag, "done seen", done_o, 1);
    chk(err_o === exp_err, tag, "error flag", err_o, exp_err);
    if (!wr) chk(rd_data_o === exp_rd, tag, "read data", rd_data_o, exp_rd);
    chk(got_q.size() == exp_q.size(), tag, "command count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] === exp_q[i], tag, "command", got_q[i], exp_q[i]);
    @(negedge clk_i);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R10", "idle after done", {busy_o, done_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_2b07));
    for (int i = 0; i < 128; i++) begin fmem[i] = 16'hFFFF; r_data[i] = 16'hFFFF; end
    for (int i = 0; i < NZ*LB; i++) begin r_vld[i] = 0; r_pb[i] = 0; r_pv[i] = 0; end
    for (int z = 0; z < NZ; z++) begin
      fh[z] = 0; fc[z] = ZB;
      for (int b = 0; b < ZB; b++) fq[z][b] = b;
    end
    repeat (2) @(negedge clk_i);
    chk(busy_o === 0 && done_o === 0 && cmd_valid_o === 0, "R12", "in reset",
        {busy_o, done_o, cmd_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 0 && done_o === 0 && cmd_valid_o === 0, "R12", "after reset",
        {busy_o, done_o, cmd_valid_o}, 0);

    do_req(0, 0, 0, 1, 0, -1, 0, "R7");             // unwritten read: ones, no cmd
    do_req(1, 0, 0, 1, 16'hA001, -1, 0, "R2");      // fresh map, block 0
    do_req(1, 0, 0, 2, 16'hA002, -1, 0, "R3");      // copy p1, prog p2, erase 0
    do_req(1, 0, 0, 0, 16'hA003, -1, 0, "R3");      // copy p1,p2 around prog p0
    do_req(0, 0, 0, 1, 0, -1, 0, "R7");
    do_req(0, 0, 0, 2, 0, -1, 0, "R7");
    do_req(1, 1, 2, 3, 16'hB000, -1, 0, "R1");
    for (int k = 0; k < 10; k++)                   // rotation through FIFO
      do_req(1, 1, 2, 3, 16'(16'hB100 + k), -1, 0, "R4");
    do_req(0, 1, 2, 3, 0, -1, 0, "R4");
    do_req(1, 0, 6, 0, 16'h1111, -1, 0, "R8");
    do_req(0, 2, 7, 1, 0, -1, 0, "R8");
    do_req(1, 0, 1, 0, 16'hC000, -1, 1, "R10");     // spurious request held while busy
    do_req(0, 0, 5, 3, 0, -1, 0, "R10");            // spurious write had no effect
    do_req(1, 2, 0, 0, 16'hD000, -1, 0, "R2");
    do_req(1, 2, 0, 1, 16'hD001, OP_PR, 0, "R6");
    do_req(0, 2, 0, 1, 0, -1, 0, "R6");
    do_req(0, 2, 0, 0, 0, -1, 0, "R6");
    do_req(1, 2, 0, 2, 16'hD002, -1, 0, "R6");
    for (int l = 0; l < LB; l++) do_req(1, 3, l, 0, 16'(16'hE000 + l), -1, 0, "R2");
    do_req(1, 3, 0, 1, 16'hE100, OP_ER, 0, "R5");
    do_req(1, 3, 1, 1, 16'hE101, OP_ER, 0, "R5");
    do_req(0, 3, 0, 1, 0, -1, 0, "R5");
    do_req(1, 3, 2, 1, 16'hE102, -1, 0, "R9");
    do_req(0, 3, 2, 0, 0, -1, 0, "R9");
    do_req(0, 3, 2, 1, 0, -1, 0, "R9");

    for (int k = 0; k < 400; k++) begin
      int inj, r;
      r = $urandom % 100;
      inj = (r == 0) ? OP_PR : (r == 1) ? OP_ER : -1;
      do_req(($urandom % 10) < 6, $urandom % 3, $urandom % 7, $urandom % 4,
             16'($urandom), inj, 0, "R11");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule